// File: doc/BRIEF.md
# Timer Software Event Generator

This block holds the software-forced event logic of a general-purpose timer that has four capture/compare channels and a break input. A single-cycle write of a command word asks for any mix of events: counter update, forced capture/compare on channels 1 to 4, control update, trigger and break. Each requested event sets its status flag. It also sends a one-cycle interrupt pulse and a one-cycle DMA pulse when the matching enable bit is set. The command word is not stored, so nothing is left pending after the write.

The block also contains the prescaler and the main counter. These run in up, down or center-aligned mode. A natural counter wrap raises the same update flag as a forced update. A forced capture works differently for each channel direction. On an input channel it latches the live counter value and can flag an overcapture. On an output channel it only sets the channel flag. A forced break drops the main-output-enable bit. A forced control update copies the preloaded enable and output-mode settings of the three complementary channels, but only when preload control is on.

Top module: `tmr_evtgen`

## Requirements
- R1: After reset, all status flags, overcapture flags, capture registers, the counter, the interrupt and DMA pulses, the main-output-enable bit and the active channel settings are zero.
- R2: Command bit 0 (update) sets flag bit 0, clears the prescaler count and reloads the counter with the auto-reload value in down mode (cnt_mode=1), or with zero in up (0) and center-aligned (2) modes. The result is visible after the write edge.
- R3: Command bits 1 to 4 force capture/compare on channels 1 to 4. For a channel whose ch_is_input bit is 0, only flag bit 1 to 4 is set. Its capture register keeps its value.
- R4: For a channel whose ch_is_input bit is 1, a forced capture copies the counter value seen in the write cycle, before any update in the same write, into that channel's capture register and sets its flag.
- R5: If an input channel's flag is already set when a forced capture arrives, its overcapture flag (ovc bit ch-1) is also set.
- R6: Command bit 6 sets trigger flag bit 6. Command bit 7 sets break flag bit 7 and clears main-output-enable, even when moe_set is high in the same cycle.
- R7: Command bit 5 sets flag bit 5. When ccpc is 1 it also copies pre_chen and pre_ocm into act_chen and act_ocm. When ccpc is 0 the active settings do not change.
- R8: For each event bit i, irq_pulse[i] and dma_pulse[i] are high for exactly the one cycle after the write, gated by irq_en[i] and dma_en[i] respectively.
- R9: Command bits written 0, bits 15:8, and any data presented while cmd_we is low have no effect.
- R10: With clr_we high, a 0 in clr_wdata bits 7:0 clears the matching status flag and a 0 in bits 11:8 clears the matching overcapture flag. A 1 leaves the flag unchanged. A hardware set in the same cycle wins over the clear.
- R11: With cnt_en high the counter steps once every psc_ratio+1 cycles. In up mode it wraps from arr to 0, and in down mode from 0 to arr. Each wrap sets flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word, bits 7:0 are event requests |
| clr_we | input | 1 | Flag clear write strobe |
| clr_wdata | input | 12 | Flag clear data, 0 clears (7:0 status, 11:8 overcapture) |
| cnt_en | input | 1 | Counter enable |
| cnt_mode | input | 2 | 0 up, 1 down, 2 center-aligned |
| psc_ratio | input | 16 | Prescaler ratio minus one |
| arr | input | 16 | Auto-reload value |
| ch_is_input | input | 4 | Per-channel direction, 1 means input |
| irq_en | input | 8 | Interrupt enables per event |
| dma_en | input | 8 | DMA enables per event |
| moe_set | input | 1 | Software set of main-output-enable |
| ccpc | input | 1 | Preload control for channel settings |
| pre_chen | input | 6 | Preloaded enable pairs, channels 1 to 3 |
| pre_ocm | input | 9 | Preloaded output modes, channels 1 to 3 |
| cnt | output | 16 | Main counter value |
| cap_val | output | 64 | Capture registers, channel n at bits 16n-1:16(n-1) |
| flags | output | 8 | Status flags, bit order as the command bits |
| ovc | output | 4 | Overcapture flags, channels 1 to 4 |
| irq_pulse | output | 8 | Interrupt request pulses |
| dma_pulse | output | 8 | DMA request pulses |
| moe | output | 1 | Main-output-enable |
| act_chen | output | 6 | Active enable pairs |
| act_ocm | output | 9 | Active output modes |

## Verification
Two pairs of functions can meet in one cycle, and the bench forces each pair into a single write. In the first pair, one command word carries both a forced capture on an input channel and an update. The check is that the capture register holds the counter value from before the write while the counter itself reads zero. In the second pair, a command write and a flag clear write fall on the same edge for the same flag. The check is that the flag stays set, and that a later clear on its own does remove it.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam int EV_N    = 8;
    localparam int CH_N    = 4;
    localparam int EV_UPD  = 0;
    localparam int EV_CC1  = 1;
    localparam int EV_COM  = 5;
    localparam int EV_TRG  = 6;
    localparam int EV_BRK  = 7;
    localparam int COMP_CH = 3;
    localparam int OCM_W   = 3;

    localparam logic [1:0] MODE_UP     = 2'd0;
    localparam logic [1:0] MODE_DOWN   = 2'd1;
    localparam logic [1:0] MODE_CENTER = 2'd2;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_evt_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output logic [EV_N-1:0]  ev
);
    logic unused_rsvd;

    always_comb begin
        ev = we ? wdata[EV_N-1:0] : '0;
    end

    assign unused_rsvd = ^wdata[CMD_W-1:EV_N];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [PSC_W-1:0] psc_ratio,
    input  logic [CNT_W-1:0] arr,
    input  logic             sw_upd,
    output logic [CNT_W-1:0] cnt,
    output logic             hw_upd
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d   = st_q;
        hw_upd = 1'b0;
        tick   = en && (st_q.psc == psc_ratio);
        if (sw_upd) begin
            st_d.psc  = '0;
            st_d.cnt  = (mode == MODE_DOWN) ? arr : '0;
            st_d.down = 1'b0;
        end else if (en) begin
            if (tick) begin
                st_d.psc = '0;
                case (mode)
                    MODE_DOWN: begin
                        if (st_q.cnt == '0) begin
                            st_d.cnt = arr;
                            hw_upd   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_ONE;
                        end
                    end
                    MODE_CENTER: begin
                        if (!st_q.down) begin
                            if (st_q.cnt >= arr) begin
                                st_d.down = 1'b1;
                                st_d.cnt  = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_ONE;
                                hw_upd    = 1'b1;
                            end else begin
                                st_d.cnt = st_q.cnt + CNT_ONE;
                            end
                        end else begin
                            if (st_q.cnt == '0) begin
                                st_d.down = 1'b0;
                                st_d.cnt  = (arr == '0) ? '0 : CNT_ONE;
                                hw_upd    = 1'b1;
                            end else begin
                                st_d.cnt = st_q.cnt - CNT_ONE;
                            end
                        end
                    end
                    default: begin
                        if (st_q.cnt >= arr) begin
                            st_d.cnt = '0;
                            hw_upd   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_ONE;
                        end
                    end
                endcase
            end else begin
                st_d.psc = st_q.psc + PSC_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EV_N-1:0]      ev,
    input  logic                 hw_upd,
    input  logic [CH_N-1:0]      ch_in,
    input  logic                 clr_we,
    input  logic [EV_N+CH_N-1:0] clr_wdata,
    input  logic [EV_N-1:0]      ien,
    input  logic [EV_N-1:0]      den,
    output logic [EV_N-1:0]      flags,
    output logic [CH_N-1:0]      ovc,
    output logic [EV_N-1:0]      irq,
    output logic [EV_N-1:0]      dma
);
    typedef struct packed {
        logic [EV_N-1:0] flags;
        logic [CH_N-1:0] ovc;
        logic [EV_N-1:0] irq;
        logic [EV_N-1:0] dma;
    } flg_st_t;

    flg_st_t                st_d, st_q;
    logic [EV_N-1:0]        set_v;
    logic [CH_N-1:0]        ovc_set;
    logic [EV_N+CH_N-1:0]   keep;

    always_comb begin
        set_v         = ev;
        set_v[EV_UPD] = ev[EV_UPD] | hw_upd;
        for (int i = 0; i < CH_N; i++) begin
            ovc_set[i] = ev[EV_CC1+i] & ch_in[i] & st_q.flags[EV_CC1+i];
        end
        keep       = clr_we ? clr_wdata : '1;
        st_d.flags = (st_q.flags & keep[EV_N-1:0]) | set_v;
        st_d.ovc   = (st_q.ovc & keep[EV_N +: CH_N]) | ovc_set;
        st_d.irq   = set_v & ien;
        st_d.dma   = set_v & den;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
    assign ovc   = st_q.ovc;
    assign irq   = st_q.irq;
    assign dma   = st_q.dma;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH_N-1:0]       cc_ev,
    input  logic [CH_N-1:0]       ch_in,
    input  logic [CNT_W-1:0]      cnt,
    output logic [CH_N*CNT_W-1:0] cap_flat
);
    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic [CNT_W-1:0] cap_d, cap_q;

        always_comb begin
            cap_d = (cc_ev[g] && ch_in[g]) ? cnt : cap_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q <= '0;
            end else begin
                cap_q <= cap_d;
            end
        end

        assign cap_flat[g*CNT_W +: CNT_W] = cap_q;
    end
endmodule

// File: rtl/tmr_evtgen.sv
module tmr_evtgen
    import tmr_evt_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_we,
    input  logic [CMD_W-1:0]             cmd_wdata,
    input  logic                         clr_we,
    input  logic [EV_N+CH_N-1:0]         clr_wdata,
    input  logic                         cnt_en,
    input  logic [1:0]                   cnt_mode,
    input  logic [PSC_W-1:0]             psc_ratio,
    input  logic [CNT_W-1:0]             arr,
    input  logic [CH_N-1:0]              ch_is_input,
    input  logic [EV_N-1:0]              irq_en,
    input  logic [EV_N-1:0]              dma_en,
    input  logic                         moe_set,
    input  logic                         ccpc,
    input  logic [2*COMP_CH-1:0]         pre_chen,
    input  logic [OCM_W*COMP_CH-1:0]     pre_ocm,
    output logic [CNT_W-1:0]             cnt,
    output logic [CH_N*CNT_W-1:0]        cap_val,
    output logic [EV_N-1:0]              flags,
    output logic [CH_N-1:0]              ovc,
    output logic [EV_N-1:0]              irq_pulse,
    output logic [EV_N-1:0]              dma_pulse,
    output logic                         moe,
    output logic [2*COMP_CH-1:0]         act_chen,
    output logic [OCM_W*COMP_CH-1:0]     act_ocm
);
    typedef struct packed {
        logic                     moe;
        logic [2*COMP_CH-1:0]     chen;
        logic [OCM_W*COMP_CH-1:0] ocm;
    } ctl_st_t;

    logic [EV_N-1:0] ev_w;
    logic            hw_upd_w;
    ctl_st_t         ctl_d, ctl_q;

    tmr_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .we    (cmd_we),
        .wdata (cmd_wdata),
        .ev    (ev_w)
    );

    tmr_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cnt_en),
        .mode      (cnt_mode),
        .psc_ratio (psc_ratio),
        .arr       (arr),
        .sw_upd    (ev_w[EV_UPD]),
        .cnt       (cnt),
        .hw_upd    (hw_upd_w)
    );

    tmr_flags u_flg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_w),
        .hw_upd    (hw_upd_w),
        .ch_in     (ch_is_input),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .ien       (irq_en),
        .den       (dma_en),
        .flags     (flags),
        .ovc       (ovc),
        .irq       (irq_pulse),
        .dma       (dma_pulse)
    );

    tmr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cc_ev    (ev_w[EV_CC1 +: CH_N]),
        .ch_in    (ch_is_input),
        .cnt      (cnt),
        .cap_flat (cap_val)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (moe_set) begin
            ctl_d.moe = 1'b1;
        end
        if (ev_w[EV_BRK]) begin
            ctl_d.moe = 1'b0;
        end
        if (ev_w[EV_COM] && ccpc) begin
            ctl_d.chen = pre_chen;
            ctl_d.ocm  = pre_ocm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign moe      = ctl_q.moe;
    assign act_chen = ctl_q.chen;
    assign act_ocm  = ctl_q.ocm;
endmodule

// File: rtl/tmr_evtgen_chk.sv
module tmr_evtgen_chk
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EV_N-1:0]       ev,
    input logic [CH_N-1:0]       ch_in,
    input logic                  moe,
    input logic [EV_N-1:0]       flags,
    input logic [CH_N-1:0]       ovc,
    input logic [EV_N-1:0]       irq,
    input logic [EV_N-1:0]       ien,
    input logic [CNT_W-1:0]      cnt,
    input logic [CNT_W-1:0]      arr,
    input logic [1:0]            mode,
    input logic [CH_N*CNT_W-1:0] cap_flat
);
    assert_break_moe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_BRK] |=> !moe);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((flags & $past(ev)) == $past(ev)));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> ((irq & ~$past(ien)) == '0));

    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~flags) == '0);

    assert_upd_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_UPD] |=> (cnt == (($past(mode) == MODE_DOWN) ? $past(arr) : '0)));

    for (genvar g = 0; g < CH_N; g++) begin : g_chk
        assert_ovc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovc[g]) |-> ($past(flags[EV_CC1+g]) && $past(ev[EV_CC1+g]) && $past(ch_in[g])));

        assert_cap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(ev[EV_CC1+g] && ch_in[g]) |=> $stable(cap_flat[g*CNT_W +: CNT_W]));
    end
endmodule

bind tmr_evtgen tmr_evtgen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_w),
    .ch_in    (ch_is_input),
    .moe      (moe),
    .flags    (flags),
    .ovc      (ovc),
    .irq      (irq_pulse),
    .ien      (irq_en),
    .cnt      (cnt),
    .arr      (arr),
    .mode     (cnt_mode),
    .cap_flat (cap_val)
);

// File: tb/tmr_evtgen_tb.sv
module tmr_evtgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        clr_we = 1'b0;
    logic [11:0] clr_wdata = '1;
    logic        cnt_en = 1'b0;
    logic [1:0]  cnt_mode = 2'd0;
    logic [15:0] psc_ratio = '0;
    logic [15:0] arr = 16'd9;
    logic [3:0]  ch_is_input = '0;
    logic [7:0]  irq_en = '0;
    logic [7:0]  dma_en = '0;
    logic        moe_set = 1'b0;
    logic        ccpc = 1'b0;
    logic [5:0]  pre_chen = '0;
    logic [8:0]  pre_ocm = '0;
    logic [15:0] cnt;
    logic [63:0] cap_val;
    logic [7:0]  flags;
    logic [3:0]  ovc;
    logic [7:0]  irq_pulse;
    logic [7:0]  dma_pulse;
    logic        moe;
    logic [5:0]  act_chen;
    logic [8:0]  act_ocm;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tmr_evtgen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .cnt_en(cnt_en), .cnt_mode(cnt_mode),
        .psc_ratio(psc_ratio), .arr(arr), .ch_is_input(ch_is_input), .irq_en(irq_en),
        .dma_en(dma_en), .moe_set(moe_set), .ccpc(ccpc), .pre_chen(pre_chen),
        .pre_ocm(pre_ocm), .cnt(cnt), .cap_val(cap_val), .flags(flags), .ovc(ovc),
        .irq_pulse(irq_pulse), .dma_pulse(dma_pulse), .moe(moe), .act_chen(act_chen),
        .act_ocm(act_ocm)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one edge with optional command and clear writes; returns just after the edge
    task automatic cyc(input logic cwe, input logic [15:0] cd, input logic kwe, input logic [11:0] kd);
        @(negedge clk);
        cmd_we = cwe; cmd_wdata = cd; clr_we = kwe; clr_wdata = kd;
        @(posedge clk); #1;
        cmd_we = 1'b0; cmd_wdata = '0; clr_we = 1'b0; clr_wdata = '1;
    endtask

    task automatic cmd(input logic [15:0] cd);
        cyc(1'b1, cd, 1'b0, 12'hFFF);
    endtask

    task automatic clear_all();
        cyc(1'b0, 16'h0, 1'b1, 12'h000);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset();
        check("R1 flags", flags, 0);
        check("R1 ovc", ovc, 0);
        check("R1 cnt", cnt, 0);
        check("R1 cap", cap_val, 0);
        check("R1 pulses", {irq_pulse, dma_pulse}, 0);
        check("R1 moe/act", {moe, act_chen, act_ocm}, 0);
    endtask

    task automatic t_update();
        cnt_mode = 2'd1; arr = 16'd9;
        cmd(16'h0001);
        check("R2 down reload", cnt, 16'd9);
        check("R2 update flag", flags[0], 1'b1);
        cnt_mode = 2'd2;
        cmd(16'h0001);
        check("R2 center reload", cnt, 16'd0);
        // prescaler restart
        cnt_mode = 2'd0; arr = 16'd1000; psc_ratio = 16'd3; cnt_en = 1'b1;
        idle(6);
        cmd(16'h0001);
        check("R2 counter zero after update", cnt, 16'd0);
        idle(3);
        check("R11 prescaler hold", cnt, 16'd0);
        idle(1);
        check("R11 prescaler step", cnt, 16'd1);
        cnt_en = 1'b0; psc_ratio = 16'd0;
    endtask

    task automatic t_run();
        cnt_mode = 2'd0; arr = 16'd3;
        cmd(16'h0001);
        clear_all();
        cnt_en = 1'b1;
        idle(3);
        check("R11 up count", cnt, 16'd3);
        check("R11 no update yet", flags[0], 1'b0);
        idle(1);
        check("R11 up wrap", cnt, 16'd0);
        check("R11 up wrap flag", flags[0], 1'b1);
        cnt_en = 1'b0;
        cnt_mode = 2'd1;
        cmd(16'h0001);
        clear_all();
        cnt_en = 1'b1;
        idle(3);
        check("R11 down count", cnt, 16'd0);
        idle(1);
        check("R11 down wrap", cnt, 16'd3);
        check("R11 down wrap flag", flags[0], 1'b1);
        cnt_en = 1'b0;
    endtask

    task automatic t_cc_output();
        ch_is_input = 4'b0000;
        clear_all();
        cmd(16'h0004);
        check("R3 ch2 flag", flags, 8'h04);
        check("R3 cap unchanged", cap_val, 64'h0);
        cmd(16'h0004);
        check("R3 no ovc on output", ovc, 4'h0);
    endtask

    task automatic t_cc_input();
        cnt_mode = 2'd0; arr = 16'd100; psc_ratio = 16'd0;
        cmd(16'h0001);
        cnt_en = 1'b1;
        idle(5);
        cnt_en = 1'b0;
        check("R11 count to five", cnt, 16'd5);
        ch_is_input = 4'b1000;
        clear_all();
        cmd(16'h0010);
        check("R4 ch4 capture", cap_val[63:48], 16'd5);
        check("R4 ch4 flag", flags, 8'h10);
        check("R5 no ovc first", ovc, 4'h0);
        cmd(16'h0010);
        check("R5 ovc ch4", ovc, 4'h8);
        ch_is_input = 4'b1001;
        cmd(16'h0003);
        check("R4 capture before update", cap_val[15:0], 16'd5);
        check("R2 update same write", cnt, 16'd0);
    endtask

    task automatic t_trig_break();
        clear_all();
        @(negedge clk); moe_set = 1'b1;
        @(posedge clk); #1; moe_set = 1'b0;
        check("R6 moe set", moe, 1'b1);
        cmd(16'h00C0);
        check("R6 trig+break flags", flags, 8'hC0);
        check("R6 moe cleared", moe, 1'b0);
        @(negedge clk); moe_set = 1'b1; cmd_we = 1'b1; cmd_wdata = 16'h0080;
        @(posedge clk); #1; moe_set = 1'b0; cmd_we = 1'b0; cmd_wdata = '0;
        check("R6 break beats set", moe, 1'b0);
    endtask

    task automatic t_com();
        clear_all();
        pre_chen = 6'b101101; pre_ocm = 9'b110_011_101; ccpc = 1'b0;
        cmd(16'h0020);
        check("R7 com flag", flags, 8'h20);
        check("R7 no copy without preload", {act_chen, act_ocm}, 0);
        ccpc = 1'b1;
        cmd(16'h0020);
        check("R7 copy with preload", {act_chen, act_ocm}, {6'b101101, 9'b110_011_101});
        ccpc = 1'b0;
    endtask

    task automatic t_pulses();
        clear_all();
        irq_en = 8'h40; dma_en = 8'h80;
        cmd(16'h00C0);
        check("R8 irq gated", irq_pulse, 8'h40);
        check("R8 dma gated", dma_pulse, 8'h80);
        idle(1);
        check("R8 single cycle", {irq_pulse, dma_pulse}, 0);
        irq_en = 8'h00; dma_en = 8'h00;
        cmd(16'h0040);
        check("R8 disabled no pulse", {irq_pulse, dma_pulse}, 0);
    endtask

    task automatic t_zero();
        logic [15:0] c0;
        logic [63:0] k0;
        logic        m0;
        clear_all();
        c0 = cnt; k0 = cap_val; m0 = moe;
        cmd(16'hFF00);
        check("R9 reserved bits", {flags, ovc}, 0);
        check("R9 state kept", {cnt, moe}, {c0, m0});
        cyc(1'b0, 16'h00FF, 1'b0, 12'hFFF);
        check("R9 no strobe", {flags, ovc}, 0);
        check("R9 cap kept", cap_val, k0);
    endtask

    task automatic t_clear();
        clear_all();
        ch_is_input = 4'b0001;
        cmd(16'h00C2);
        cmd(16'h0002);
        check("R10 setup", {flags, ovc}, {8'hC2, 4'h1});
        cyc(1'b1, 16'h0040, 1'b1, 12'h000);
        check("R10 set wins", flags, 8'h40);
        cmd(16'h0080);
        cyc(1'b0, 16'h0, 1'b1, 12'hFBF);
        check("R10 selective clear", flags, 8'h80);
        cmd(16'h0002);
        cmd(16'h0002);
        check("R10 ovc set again", ovc, 4'h1);
        cyc(1'b0, 16'h0, 1'b1, 12'hEFF);
        check("R10 ovc clear", {flags, ovc}, {8'h82, 4'h0});
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_update();
        t_run();
        t_cc_output();
        t_cc_input();
        t_trig_break();
        t_com();
        t_pulses();
        t_zero();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule